// File: doc/BRIEF.md
# Banked RAM Cartridge Mapper with Two Sound Windows

This block sits between a CPU bus and a RAM cartridge. It splits the CPU space into four 8 KB pages. Each page has an 8-bit bank register. The RAM address it produces is that page's bank value followed by the 13-bit offset within the page. A configuration register controls two things. First, it sets, for each page, whether CPU writes reach RAM or load the bank register. Second, it picks one of two placements for a sound-register window. The mapper does not contain the RAM storage or the sound core. It drives strobes, a RAM address, a sound register offset and a layout-mode bit for them.

Every output is registered. The access sampled at a rising clock edge appears on the outputs just after that edge. The decode uses the configuration and bank values that held before that edge. Any register update made by the access therefore takes effect from the next access.

Top module: `bankmap_top`

## Requirements
- R1: After reset the configuration register is zero, so `snd_mode` is 0 and every page is in bank-select mode. Bank register k starts at value k. No strobe is asserted.
- R2: Each read or write loads `ram_addr` with {bank of the selected page, addr[12:0]}. The page is {~addr[14], addr[13]}, so the windows 0x4000, 0x6000, 0x8000 and 0xA000 select pages 0 to 3. The windows 0xC000, 0xE000, 0x0000 and 0x2000 mirror pages 0, 1, 2 and 3.
- R3: A write to the range 0x5000–0x57FF, 0x7000–0x77FF, 0x9000–0x97FF or 0xB000–0xB7FF (any byte of the range) loads that page's bank register with the full 8-bit data. This holds only when the page is in bank-select mode, and the write raises no RAM strobe. The mirror windows outside 0x4000–0xBFFF never load a bank register.
- R4: A write to 0xBFFE or 0xBFFF loads the configuration register. It raises neither the RAM strobe nor a sound strobe. `snd_mode` then equals data bit 5, where 0 means the compatibility layout and 1 means the extended layout.
- R5: When configuration bit 4 is 1, every page is in RAM-write mode. Writes then pulse `ram_we`, and no bank register changes, including for writes inside the bank ranges.
- R6: When configuration bit 4 is 0, bits 0, 1 and 2 put pages 0, 1 and 2 in RAM-write mode, and page 3 stays in bank-select mode. A write to a page in bank-select mode never pulses `ram_we`.
- R7: In compatibility mode, if the low six bits of bank 2 are all ones (0x3F), accesses to 0x9800–0x9FFF pulse `snd_rd` or `snd_wr`, with `snd_off` = addr[7:0]. In extended mode this window is closed.
- R8: In extended mode, if bit 7 of bank 3 is 1, accesses to 0xB800–0xBFFF pulse `snd_rd` or `snd_wr`, with `snd_off` = addr[7:0]. As a result, 0xB900–0xBFFF mirror 0xB800–0xB8FF. The exception is a write to 0xBFFE/0xBFFF, which goes only to the configuration register. In compatibility mode this window is closed.
- R9: A write that hits an open sound window never pulses `ram_we`, even when its page is in RAM-write mode.
- R10: Strobes are single-cycle pulses that follow the sampled access by one clock. While the bus is idle, `ram_addr` and `snd_off` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write cycle, sampled each clock |
| cpu_rd | input | 1 | Read cycle, sampled each clock (ignored while cpu_wr is high) |
| ram_addr | output | 21 | RAM address: bank and page offset |
| ram_we | output | 1 | RAM write strobe |
| snd_rd | output | 1 | Sound core read select |
| snd_wr | output | 1 | Sound core write select |
| snd_off | output | 8 | Local register offset in the sound core |
| snd_mode | output | 1 | Register layout for the sound core: 0 compatibility, 1 extended |

## Verification
The extended sound window covers the configuration address. A single write to 0xBFFE can therefore hit both the window and the configuration register. The bench opens the window, selects RAM-write mode for all pages, and then writes 0xBFFE/0xBFFF. It expects the configuration change to land with no sound strobe and no RAM strobe. The bench also checks two other overlaps. A write into an open window on a RAM-writable page must pulse only the sound strobe. A write into a bank range on a RAM-writable page must become a RAM write and leave the bank register unchanged, which the bench checks by reading the page back.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  localparam int CPU_AW     = 16;
  localparam int NUM_PAGES  = 4;
  localparam int PAGE_IDX_W = $clog2(NUM_PAGES);

  // 0xBFFE/0xBFFF share the upper 15 address bits
  localparam logic [14:0] CFG_ADR_HI  = 15'h5FFF;
  // compatibility window 0x9800-0x9FFF, extended window 0xB800-0xBFFF
  localparam logic [4:0]  CWIN_HI     = 5'b10011;
  localparam logic [4:0]  XWIN_HI     = 5'b10111;
  // bank ranges sit at offset 0x1000-0x17FF of each page
  localparam logic [1:0]  BANK_RNG_ID = 2'b10;

  // configuration field positions
  localparam int CFG_ALL_BIT  = 4;
  localparam int CFG_MODE_BIT = 5;

  // compatibility window key held in the page-2 bank
  localparam logic [5:0]  CWIN_KEY    = 6'h3F;

  typedef struct packed {
    logic [PAGE_IDX_W-1:0] page;
    logic                  bank_rng;
    logic                  cfg_adr;
    logic                  cwin;
    logic                  xwin;
  } dec_t;
endpackage

// File: rtl/bankmap_decode.sv
module bankmap_decode
  import bankmap_pkg::*;
(
  input  logic [CPU_AW-1:0] addr_i,
  output dec_t              dec_o
);
  logic primary;

  // pages live at 0x4000-0xBFFF; top two bits 01 or 10
  assign primary = addr_i[15] ^ addr_i[14];

  always_comb begin
    dec_o.page     = {~addr_i[14], addr_i[13]};
    dec_o.bank_rng = primary && (addr_i[12:11] == BANK_RNG_ID);
    dec_o.cfg_adr  = (addr_i[15:1] == CFG_ADR_HI);
    dec_o.cwin     = (addr_i[15:11] == CWIN_HI);
    dec_o.xwin     = (addr_i[15:11] == XWIN_HI);
  end
endmodule

// File: rtl/bankmap_cfg.sv
module bankmap_cfg
  import bankmap_pkg::*;
#(
  parameter int PAGES = NUM_PAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [PAGES-2:0] sel_i,
  input  logic             all_i,
  input  logic             mode_i,
  output logic [PAGES-1:0] ram_page_o,
  output logic             all_o,
  output logic             mode_o
);
  logic [PAGES-2:0] sel_q;
  logic             all_q;
  logic             mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      all_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (we_i) begin
      sel_q  <= sel_i;
      all_q  <= all_i;
      mode_q <= mode_i;
    end
  end

  // the last page only follows the global flag
  genvar g;
  generate
    for (g = 0; g < PAGES; g++) begin : g_pg
      if (g == PAGES-1) begin : g_last
        assign ram_page_o[g] = all_q;
      end else begin : g_sel
        assign ram_page_o[g] = all_q | sel_q[g];
      end
    end
  endgenerate

  assign all_o  = all_q;
  assign mode_o = mode_q;

  p_mode_tracks_r4: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (mode_o == $past(mode_i)));
  p_last_page_r6: assert property (@(posedge clk) disable iff (rst)
    !all_o |-> !ram_page_o[PAGES-1]);
endmodule

// File: rtl/bankmap_banks.sv
module bankmap_banks
  import bankmap_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int PAGES  = NUM_PAGES,
  localparam int IDX_W = $clog2(PAGES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [BANK_W-1:0]       wdata_i,
  output logic [PAGES*BANK_W-1:0] banks_o
);
  genvar g;
  generate
    for (g = 0; g < PAGES; g++) begin : g_bank
      logic [BANK_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= BANK_W'(g);
        else if (we_i && (idx_i == IDX_W'(g)))
          q <= wdata_i;
      end
      assign banks_o[g*BANK_W +: BANK_W] = q;
    end
  endgenerate
endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
  import bankmap_pkg::*;
#(
  parameter int BANK_W     = 8,
  parameter int PAGE_OFF_W = 13,
  parameter int SND_OFF_W  = 8,
  localparam int RAM_AW    = BANK_W + PAGE_OFF_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CPU_AW-1:0]    cpu_addr,
  input  logic [BANK_W-1:0]    cpu_wdata,
  input  logic                 cpu_wr,
  input  logic                 cpu_rd,
  output logic [RAM_AW-1:0]    ram_addr,
  output logic                 ram_we,
  output logic                 snd_rd,
  output logic                 snd_wr,
  output logic [SND_OFF_W-1:0] snd_off,
  output logic                 snd_mode
);
  dec_t                      dec;
  logic [NUM_PAGES-1:0]      ram_page;
  logic                      all_ram;
  logic                      mode;
  logic [NUM_PAGES*BANK_W-1:0] banks;
  logic [BANK_W-1:0]         cur_bank;
  logic                      rd_eff;
  logic                      cfg_we;
  logic                      bank_we;
  logic                      pg_ram;
  logic                      cwin_open;
  logic                      xwin_open;
  logic                      snd_hit;
  logic                      ram_wr_en;

  bankmap_decode u_dec (
    .addr_i (cpu_addr),
    .dec_o  (dec)
  );

  bankmap_cfg #(.PAGES(NUM_PAGES)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .we_i       (cfg_we),
    .sel_i      (cpu_wdata[NUM_PAGES-2:0]),
    .all_i      (cpu_wdata[CFG_ALL_BIT]),
    .mode_i     (cpu_wdata[CFG_MODE_BIT]),
    .ram_page_o (ram_page),
    .all_o      (all_ram),
    .mode_o     (mode)
  );

  bankmap_banks #(.BANK_W(BANK_W), .PAGES(NUM_PAGES)) u_banks (
    .clk     (clk),
    .rst     (rst),
    .we_i    (bank_we),
    .idx_i   (dec.page),
    .wdata_i (cpu_wdata),
    .banks_o (banks)
  );

  always_comb begin
    rd_eff    = cpu_rd & ~cpu_wr;
    cur_bank  = banks[dec.page*BANK_W +: BANK_W];
    pg_ram    = ram_page[dec.page];
    cwin_open = !mode && (banks[2*BANK_W +: 6] == CWIN_KEY);
    xwin_open = mode && banks[3*BANK_W + BANK_W-1];
    // configuration writes win over the extended window that covers them
    snd_hit   = (dec.cwin && cwin_open) ||
                (dec.xwin && xwin_open && !(cpu_wr && dec.cfg_adr));
    cfg_we    = cpu_wr && dec.cfg_adr;
    bank_we   = cpu_wr && dec.bank_rng && !pg_ram;
    ram_wr_en = cpu_wr && pg_ram && !snd_hit && !dec.cfg_adr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr <= '0;
      ram_we   <= 1'b0;
      snd_rd   <= 1'b0;
      snd_wr   <= 1'b0;
      snd_off  <= '0;
    end else begin
      ram_we <= ram_wr_en;
      snd_rd <= rd_eff & snd_hit;
      snd_wr <= cpu_wr & snd_hit;
      if (cpu_wr | rd_eff)
        ram_addr <= {cur_bank, cpu_addr[PAGE_OFF_W-1:0]};
      if ((cpu_wr | rd_eff) && snd_hit)
        snd_off <= cpu_addr[SND_OFF_W-1:0];
    end
  end

  assign snd_mode = mode;

  p_cfg_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (!ram_we && !snd_wr));
  p_bank_lock_r5: assert property (@(posedge clk) disable iff (rst)
    all_ram |=> $stable(banks));
  p_ram_we_src_r6: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(cpu_wr));
  p_snd_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({snd_rd, snd_wr}));
  p_snd_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && snd_wr));
endmodule

// File: tb/bankmap_top_tb.sv
module bankmap_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [20:0] ram_addr;
  logic        ram_we, snd_rd, snd_wr, snd_mode;
  logic [7:0]  snd_off;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  bankmap_top u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ram_addr(ram_addr), .ram_we(ram_we),
    .snd_rd(snd_rd), .snd_wr(snd_wr), .snd_off(snd_off), .snd_mode(snd_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle; on return the outputs show the result of that access
  task automatic acc(input logic [15:0] a, input logic [7:0] d, input logic w);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = ~w;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic rd_page(input string tag, input logic [15:0] a, input logic [7:0] bank);
    acc(a, 8'h00, 1'b0);
    chk(tag, 32'(ram_addr), 32'({bank, a[12:0]}));
  endtask

  task automatic t_reset;
    chk("R1 mode", 32'(snd_mode), 0);
    chk("R1 strobes", 32'({ram_we, snd_rd, snd_wr}), 0);
    rd_page("R1 page0", 16'h4005, 8'h00);
    rd_page("R1 page1", 16'h6010, 8'h01);
    rd_page("R1 page2", 16'h8000, 8'h02);
    rd_page("R1 page3", 16'hA123, 8'h03);
  endtask

  task automatic t_mirror;
    rd_page("R2 mirror C000", 16'hC001, 8'h00);
    rd_page("R2 mirror E000", 16'hE004, 8'h01);
    rd_page("R2 mirror 0000", 16'h0002, 8'h02);
    rd_page("R2 mirror 2000", 16'h3FFF, 8'h03);
  endtask

  task automatic t_bank_select;
    acc(16'h5000, 8'h12, 1'b1);
    chk("R3 no ram_we on bank write", 32'(ram_we), 0);
    acc(16'h77FF, 8'h34, 1'b1);
    rd_page("R3 page0 bank", 16'h4100, 8'h12);
    rd_page("R3 page1 bank via last byte", 16'h6200, 8'h34);
    acc(16'hD000, 8'h55, 1'b1);
    chk("R3 mirror write no ram_we", 32'(ram_we), 0);
    rd_page("R3 mirror write ignored", 16'h4000, 8'h12);
  endtask

  task automatic t_page_ram;
    acc(16'hBFFE, 8'h01, 1'b1);
    acc(16'h4005, 8'hAA, 1'b1);
    chk("R6 page0 ram_we", 32'(ram_we), 1);
    chk("R6 page0 addr", 32'(ram_addr), 32'({8'h12, 13'h0005}));
    acc(16'h5000, 8'h99, 1'b1);
    chk("R6 bank range is RAM", 32'(ram_we), 1);
    rd_page("R6 bank0 kept", 16'h4000, 8'h12);
    acc(16'h6000, 8'h11, 1'b1);
    chk("R6 page1 no ram_we", 32'(ram_we), 0);
    acc(16'hA000, 8'h11, 1'b1);
    chk("R6 page3 no ram_we", 32'(ram_we), 0);
  endtask

  task automatic t_all_ram;
    acc(16'hBFFE, 8'h10, 1'b1);
    acc(16'hB000, 8'h80, 1'b1);
    chk("R5 page3 ram_we", 32'(ram_we), 1);
    chk("R5 page3 addr", 32'(ram_addr), 32'({8'h03, 13'h1000}));
    rd_page("R5 bank3 kept", 16'hA000, 8'h03);
    acc(16'h9000, 8'h3F, 1'b1);
    chk("R5 page2 ram_we", 32'(ram_we), 1);
    rd_page("R5 bank2 kept", 16'h8000, 8'h02);
  endtask

  task automatic t_cfg_write;
    acc(16'hBFFF, 8'h20, 1'b1);
    chk("R4 cfg no ram_we", 32'(ram_we), 0);
    chk("R4 cfg no snd", 32'({snd_rd, snd_wr}), 0);
    chk("R4 mode set", 32'(snd_mode), 1);
    acc(16'hBFFE, 8'h00, 1'b1);
    chk("R4 mode clear", 32'(snd_mode), 0);
  endtask

  task automatic t_compat_win;
    acc(16'h9000, 8'h3F, 1'b1);
    acc(16'h9800, 8'h00, 1'b0);
    chk("R7 snd_rd", 32'({snd_rd, snd_wr}), 32'b10);
    chk("R7 off", 32'(snd_off), 0);
    acc(16'h9A45, 8'h07, 1'b1);
    chk("R7 snd_wr", 32'({snd_rd, snd_wr}), 32'b01);
    chk("R7 off mirror", 32'(snd_off), 32'h45);
    @(negedge clk);
    chk("R10 strobe is a pulse", 32'({snd_wr, ram_we}), 0);
    chk("R10 offset held", 32'(snd_off), 32'h45);
    acc(16'hBFFE, 8'h20, 1'b1);
    acc(16'h9800, 8'h00, 1'b0);
    chk("R7 closed in extended", 32'(snd_rd), 0);
    acc(16'hBFFE, 8'h00, 1'b1);
    acc(16'h9000, 8'h3E, 1'b1);
    acc(16'h9800, 8'h00, 1'b0);
    chk("R7 wrong key closed", 32'(snd_rd), 0);
    acc(16'h9000, 8'h3F, 1'b1);
  endtask

  task automatic t_ext_win;
    acc(16'hB000, 8'h80, 1'b1);
    acc(16'hB800, 8'h00, 1'b0);
    chk("R8 closed in compat", 32'(snd_rd), 0);
    acc(16'hBFFE, 8'h20, 1'b1);
    acc(16'hB8AA, 8'h01, 1'b1);
    chk("R8 snd_wr", 32'(snd_wr), 1);
    chk("R8 off", 32'(snd_off), 32'hAA);
    acc(16'hBC12, 8'h00, 1'b0);
    chk("R8 mirror rd", 32'({snd_rd, snd_off}), 32'h112);
    acc(16'hBFFE, 8'h20, 1'b1);
    chk("R8 cfg addr not sound", 32'(snd_wr), 0);
  endtask

  task automatic t_overlap;
    acc(16'hBFFE, 8'h30, 1'b1);
    chk("R9 cfg in window all-RAM no strobes", 32'({ram_we, snd_wr}), 0);
    acc(16'hB805, 8'h01, 1'b1);
    chk("R9 ext window beats RAM", 32'({ram_we, snd_wr}), 32'b01);
    acc(16'hBFFE, 8'h10, 1'b1);
    acc(16'h9805, 8'h01, 1'b1);
    chk("R9 compat window beats RAM", 32'({ram_we, snd_wr}), 32'b01);
    acc(16'h8005, 8'h01, 1'b1);
    chk("R9 outside window RAM", 32'({ram_we, snd_wr}), 32'b10);
    @(negedge clk);
    chk("R10 ram_addr held", 32'(ram_addr), 32'({8'h3F, 13'h0005}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mirror();
    t_bank_select();
    t_page_ram();
    t_all_ram();
    t_cfg_write();
    t_compat_win();
    t_ext_win();
    t_overlap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule